// File: doc/BRIEF.md
# Differential Split-Phase Line Codec

This block carries clock and data on one serial wire. The transmit half turns a bit stream into a single line level. The line always toggles when a bit cell begins. A zero bit adds a second toggle halfway through its cell, and a one bit adds none. Because every cell boundary toggles, a receiver can recover bit timing from the line alone. Line delay then has no effect on decoding, and the absolute level of the wire carries no meaning. When no valid data is offered, the transmitter sends ones, so a continuously sending station keeps toggling. Other stations can use its stream as their timing reference. The nominal rate on the shared bus is 1.8432 Mbit/s.

Both halves run on an oversampling clock, `OSR` ticks per bit cell (default 8). The transmitter tells the source when it takes the next bit. The receive half works on the sampled line and needs no separate clock input. It emits one strobe per decoded cell, and it raises a violation pulse when the line breaks the code. The receive half then hunts for the next toggle, takes it as a cell boundary and locks again. Frame delimiting, CRC checking and line drivers sit outside this block.

Top module: `dsplit_codec`

## Requirements
- R1: The line toggles at the start of every transmitted cell. Cell starts are exactly `OSR` clock cycles apart, and `tx_load` is high for one cycle in each cell.
- R2: A transmitted zero toggles the line a second time, `OSR/2` cycles after its cell start. A transmitted one has no toggle other than the one at its start.
- R3: If `tx_valid` is low in the `tx_load` cycle, the encoder sends a one (idle fill).
- R4: `tx_valid` and `tx_data` are sampled only at the rising edge that ends a `tx_load` cycle. Values presented in other cycles have no effect on the line.
- R5: While locked, the receiver measures each line toggle by its distance from the last accepted boundary, counted in samples. A toggle at 3·OSR/8 to 5·OSR/8 samples marks the cell as zero. A toggle at 5·OSR/8+1 to OSR+1 samples is taken as the next boundary. That boundary yields one `rx_valid` pulse, with `rx_data` = 0 if a mid toggle was seen and 1 if not.
- R6: The decoded bits are the same whether the line idles high or low, and also when the line is inverted.
- R7: If no toggle arrives within OSR+1 samples of a boundary, `rx_err` pulses for one cycle and no `rx_valid` is produced for that cell. The next toggle is taken as a boundary, and the cell that follows it is decoded.
- R8: While locked, a toggle earlier than 3·OSR/8 samples after a boundary, or a second toggle inside the mid window, pulses `rx_err` and drops lock. `rx_err` and `rx_valid` are never high in the same cycle.
- R9: While `rst` is high, `line_out` is low and `rx_valid` and `rx_err` are low. The receiver takes the first toggle after reset as a boundary, so the first cell the encoder sends after reset is decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OSR ticks per bit cell |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Source has a bit to send |
| tx_data | input | 1 | Bit value to send |
| tx_load | output | 1 | The encoder takes tx_valid/tx_data at the edge ending this cycle |
| line_out | output | 1 | Encoded line level |
| line_in | input | 1 | Sampled line level to decode |
| rx_valid | output | 1 | One-cycle strobe: a cell was decoded |
| rx_data | output | 1 | Decoded bit, meaningful while rx_valid is high |
| rx_err | output | 1 | One-cycle code-violation pulse |

## Verification
In the receiver, a late cell boundary and a missing one are decided on the same counter value. A toggle that arrives exactly OSR+1 samples after a boundary must be accepted as a boundary. The same count without a toggle must fire the violation. The bench drives cells stretched to OSR+1 samples, and it holds the line still well past that point. It judges the result from the decoded bit sequence and the number of `rx_err` pulses seen at the ports. Exhaustive byte sweeps in true and inverted polarity, with opposing values presented outside `tx_load`, check the encoder and decoder together.

// File: rtl/dsplit_pkg.sv
package dsplit_pkg;

    // Receiver tracking state
    typedef enum logic {
        ST_HUNT  = 1'b0,
        ST_TRACK = 1'b1
    } dec_state_e;

    // Receiver output bundle
    typedef struct packed {
        logic valid;
        logic data;
        logic err;
    } dec_out_t;

    // Window limits in samples after a boundary toggle
    function automatic int mid_lo(input int osr);
        return (3 * osr) / 8;
    endfunction

    function automatic int mid_hi(input int osr);
        return (5 * osr) / 8;
    endfunction

    function automatic int bnd_hi(input int osr);
        return osr + 1;
    endfunction

endpackage

// File: rtl/dsplit_enc.sv
module dsplit_enc #(
    parameter int OSR = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_valid,
    input  logic tx_data,
    output logic tx_load,
    output logic line_out
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    logic [CW-1:0] cnt_q;
    logic          bit_q;
    logic          line_q;

    assign tx_load  = (cnt_q == CW'(OSR - 1));
    assign line_out = line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CW'(OSR - 1);
            bit_q  <= 1'b1;
            line_q <= 1'b0;
        end else if (tx_load) begin
            cnt_q  <= '0;
            line_q <= ~line_q;
            bit_q  <= tx_valid ? tx_data : 1'b1;
        end else begin
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(HALF - 1) && !bit_q)
                line_q <= ~line_q;
        end
    end

    AST_CELL_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> (line_out != $past(line_out)));  // R1
    AST_LOAD_SPARSE: assert property (@(posedge clk) disable iff (rst)
        tx_load |=> !tx_load);  // R1
    AST_ONE_FLAT: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CW'(HALF - 1) && bit_q) |=> $stable(line_out));  // R2

endmodule

// File: rtl/dsplit_dec.sv
module dsplit_dec
    import dsplit_pkg::*;
#(
    parameter int OSR = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     line_in,
    output dec_out_t rx_o
);
    localparam int MID_LO = mid_lo(OSR);
    localparam int BND_LO = mid_hi(OSR) + 1;
    localparam int BND_HI = bnd_hi(OSR);
    localparam int CNT_W  = $clog2(BND_HI + 1);

    logic             smp_q, prev_q;
    logic [1:0]       prime_q;
    dec_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic             mid_q;
    dec_out_t         out_q;
    logic             edge_seen;

    assign edge_seen = prime_q[1] && (smp_q != prev_q);
    assign rx_o      = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q   <= 1'b0;
            prev_q  <= 1'b0;
            prime_q <= 2'b00;
            st_q    <= ST_HUNT;
            cnt_q   <= '0;
            mid_q   <= 1'b0;
            out_q   <= '0;
        end else begin
            smp_q   <= line_in;
            prev_q  <= smp_q;
            prime_q <= {prime_q[0], 1'b1};
            out_q   <= '0;
            if (st_q == ST_HUNT) begin
                if (edge_seen) begin
                    st_q  <= ST_TRACK;
                    cnt_q <= CNT_W'(1);
                    mid_q <= 1'b0;
                end
            end else if (edge_seen) begin
                if (cnt_q >= CNT_W'(BND_LO)) begin
                    out_q.valid <= 1'b1;
                    out_q.data  <= ~mid_q;
                    cnt_q       <= CNT_W'(1);
                    mid_q       <= 1'b0;
                end else if (cnt_q >= CNT_W'(MID_LO) && !mid_q) begin
                    mid_q <= 1'b1;
                    cnt_q <= cnt_q + CNT_W'(1);
                end else begin
                    out_q.err <= 1'b1;
                    st_q      <= ST_HUNT;
                end
            end else if (cnt_q == CNT_W'(BND_HI)) begin
                out_q.err <= 1'b1;
                st_q      <= ST_HUNT;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
        !(rx_o.valid && rx_o.err));  // R8
    AST_ERR_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        rx_o.err |-> (st_q == ST_HUNT));  // R7
    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (rst)
        rx_o.valid |=> !rx_o.valid);  // R5

endmodule

// File: rtl/dsplit_codec.sv
module dsplit_codec
    import dsplit_pkg::*;
#(
    parameter int OSR = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_valid,
    input  logic tx_data,
    output logic tx_load,
    output logic line_out,
    input  logic line_in,
    output logic rx_valid,
    output logic rx_data,
    output logic rx_err
);
    dec_out_t dec_out;

    dsplit_enc #(.OSR(OSR)) u_enc (
        .clk      (clk),
        .rst      (rst),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_load  (tx_load),
        .line_out (line_out)
    );

    dsplit_dec #(.OSR(OSR)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_in),
        .rx_o    (dec_out)
    );

    assign rx_valid = dec_out.valid;
    assign rx_data  = dec_out.data;
    assign rx_err   = dec_out.err;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!rx_valid && !rx_err));  // R9

endmodule

// File: tb/dsplit_codec_bench.sv
`timescale 1ns/1ps
module dsplit_codec_bench;
    localparam int OSR = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_valid = 1'b0;
    logic tx_data = 1'b0;
    logic tx_load, line_out, line_in, rx_valid, rx_data, rx_err;
    logic manual = 1'b0;
    logic man_line = 1'b0;
    logic inv = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int err_cnt = 0;
    logic rx_q[$];
    logic exp_q[$];
    logic idle_q[$];

    logic last_line, cur_bit, have_cell;
    int togs, per;

    always #10 clk = ~clk;

    assign line_in = manual ? man_line : (line_out ^ inv);

    dsplit_codec #(.OSR(OSR)) u_dsplit_codec (
        .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_load(tx_load), .line_out(line_out), .line_in(line_in),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) rx_q.push_back(rx_data);
            if (rx_err) err_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset(input logic start_level);
        rst = 1'b1;
        tx_valid = 1'b0;
        tx_data = 1'b0;
        man_line = start_level;
        repeat (3) @(negedge clk);
        chk(line_out == 1'b0, "R9 line low in reset", int'(line_out), 0);
        chk(rx_valid == 1'b0 && rx_err == 1'b0, "R9 rx quiet in reset",
            int'({rx_valid, rx_err}), 0);
        rx_q.delete(); exp_q.delete(); idle_q.delete();
        err_cnt = 0;
        rst = 1'b0;
        // first cell after release is idle fill (tx_valid low in reset), R3
        exp_q.push_back(1'b1); idle_q.push_back(1'b1);
        cur_bit = 1'b1; have_cell = 1'b1; togs = 0; per = 0; last_line = 1'b0;
    endtask

    // per-negedge encoder observation: toggles per cell (R1, R2) and cell period (R1)
    task automatic observe();
        per++;
        if (line_out != last_line) togs++;
        last_line = line_out;
        if (tx_load) begin
            if (have_cell) begin
                chk(togs == (cur_bit ? 1 : 2), cur_bit ? "R1 one-cell toggles" : "R2 zero-cell toggles",
                    togs, cur_bit ? 1 : 2);
                chk(per == OSR, "R1 cell period", per, OSR);
            end
            togs = 0;
            per = 0;
        end
    endtask

    task automatic drive_bit(input logic v, input logic d);
        logic e;
        bit got;
        e = v ? d : 1'b1;
        got = 0;
        while (!got) begin
            @(negedge clk);
            observe();
            if (tx_load) got = 1;
            else begin
                tx_valid = 1'b1;   // opposing value outside the load cycle, R4
                tx_data  = ~e;
            end
        end
        tx_valid = v;
        tx_data  = d;
        cur_bit = e;
        have_cell = 1'b1;
        exp_q.push_back(e);
        idle_q.push_back(!v);
    endtask

    task automatic run_stream(input string tag);
        for (int b = 0; b < 256; b++) begin
            if (b % 16 == 0) repeat (3) drive_bit(1'b0, 1'b0);
            for (int k = 7; k >= 0; k--) drive_bit(1'b1, b[k]);
        end
        repeat (3) drive_bit(1'b0, 1'b0);
        repeat (3 * OSR) @(negedge clk);
        chk(rx_q.size() >= exp_q.size(), {tag, " decoded count"}, rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < rx_q.size(); i++)
            chk(rx_q[i] == exp_q[i], idle_q[i] ? {tag, " R3 idle bit"} : {tag, " R4 R5 data bit"},
                int'(rx_q[i]), int'(exp_q[i]));
        chk(err_cnt == 0, {tag, " no violation on clean line"}, err_cnt, 0);
    endtask

    task automatic mcell(input logic b, input int mid, input int len);
        for (int i = 0; i < len; i++) begin
            if (i == 0) man_line = ~man_line;
            if (!b && i == mid) man_line = ~man_line;
            @(negedge clk);
        end
    endtask

    task automatic check_rx(input logic [15:0] bits, input int n, input int errs, input string tag);
        chk(rx_q.size() == n, {tag, " decoded count"}, rx_q.size(), n);
        for (int i = 0; i < n && i < rx_q.size(); i++)
            chk(rx_q[i] == bits[i], {tag, " bit"}, int'(rx_q[i]), int'(bits[i]));
        chk(err_cnt == errs, {tag, " violation count"}, err_cnt, errs);
        rx_q.delete();
        err_cnt = 0;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // sweep all bytes, line as sent
        manual = 1'b0; inv = 1'b0;
        do_reset(1'b0);
        run_stream("R5 true polarity");

        // same sweep, decoder sees the inverted line
        inv = 1'b1;
        do_reset(1'b0);
        run_stream("R6 inverted polarity");

        // hand-drawn line starting high
        manual = 1'b1;
        do_reset(1'b1);
        repeat (4) @(negedge clk);
        // mid toggles at window edges 3 and 5, boundaries at 6 and 9 samples (R5),
        // then a long hold: boundary missing (R7)
        mcell(1'b1, 0, 8);
        mcell(1'b0, 3, 8);
        mcell(1'b0, 5, 8);
        mcell(1'b1, 0, 6);
        mcell(1'b0, 4, 9);
        mcell(1'b1, 0, 8);
        mcell(1'b1, 0, 8);
        mcell(1'b1, 0, 14);
        check_rx(16'b0000_0000_0110_1001, 7, 1, "R5 R6 R7 window edges");

        // resynchronise after the violation, first cell decoded (R7)
        mcell(1'b0, 4, 8);
        mcell(1'b1, 0, 8);
        mcell(1'b1, 0, 12);
        check_rx(16'b0000_0000_0000_0010, 2, 1, "R7 resync");

        // toggle 2 samples after a boundary is a violation (R8)
        mcell(1'b0, 2, 8);
        mcell(1'b1, 0, 8);
        mcell(1'b0, 4, 8);
        mcell(1'b1, 0, 12);
        check_rx(16'b0000_0000_0000_0001, 2, 2, "R8 early toggle");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule